// File: doc/BRIEF.md
# Privilege Mode Transition Controller

This block owns the privilege bits of the processor status word and decides, cycle by cycle, whether the core runs in secure, supervisor or user mode. Two bits of the status word encode the mode: one selects secure against supervisor, and the other marks user mode. Out of reset the core is secure. Software can only give privilege away by writing the status word. Privilege comes back through exception entry alone, and the entry's vector word chooses the handler mode.

On every exception, software interrupt or hardware interrupt the fetch logic raises an entry strobe and presents the vector word it fetched. Bit 0 of that word is a flag and not part of the address. When the flag is set, the handler runs secure. When it is clear, the handler runs in supervisor mode, and this applies even when the interrupted code was secure. The block strips the flag from the vector word and returns the handler address. It also copies the interrupted status word into a single shadow register. A return strobe copies the shadow back into the status word. A restore that would reach secure mode is only honoured while the core is secure.

Any write, entry or return that attempts to gain privilege it is not entitled to raises a one-cycle violation pulse.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset deasserts, sr_o equals a word with only bit SEC_BIT (29) set, mode_o is 0 (secure), secure_o is 1 and viol_o is 0.
- R2: The mode_o encoding is 0 for secure, 1 for supervisor and 2 for user. sr_o bit USR_BIT (31) set gives user, and user wins when both bits are set. Otherwise bit 29 set gives secure, and clear gives supervisor. secure_o is 1 exactly when mode_o is 0.
- R3: An entry strobe with vector bit 0 = 1 makes the next-cycle sr_o equal the prior value with bit 31 cleared and bit 29 set, so the mode is secure.
- R4: An entry strobe with vector bit 0 = 0 makes the next-cycle sr_o equal the prior value with bits 31 and 29 cleared, so the mode is supervisor. This holds even when the core was secure.
- R5: handler_addr_o equals exc_vec_i with bit 0 forced to 0, in the same cycle and with no register in the path.
- R6: Entry saves the prior sr_o into the shadow register. A return strobe sets the next-cycle sr_o to the shadow value. The shadow value is kept after the return.
- R7: A return issued while not secure, with bit 29 set in the shadow value, restores the shadow with bit 29 cleared and pulses viol_o.
- R8: A status write issued while not secure, with bit 29 set in the write data, leaves sr_o unchanged and pulses viol_o in the next cycle.
- R9: A status write issued in user mode, with bit 31 clear in the write data, leaves sr_o unchanged and pulses viol_o.
- R10: A status write issued in secure mode, or a supervisor write that sets neither privilege-raising bit, loads the write data into sr_o in the next cycle with viol_o low.
- R11: When strobes coincide, entry wins over return and return wins over write. A strobe that loses has no effect.
- R12: viol_o goes high only in the cycle after a rejected write or a guarded return, and stays high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_valid_i | input | 1 | Exception or interrupt entry strobe |
| exc_vec_i | input | XLEN | Fetched vector word; bit 0 selects the handler mode |
| sr_we_i | input | 1 | Status-word write strobe |
| sr_wdata_i | input | XLEN | Status-word write data |
| eret_i | input | 1 | Return-from-exception strobe |
| mode_o | output | 2 | Current mode: 0 secure, 1 supervisor, 2 user |
| secure_o | output | 1 | High while in secure mode |
| sr_o | output | XLEN | Current status word |
| handler_addr_o | output | XLEN | Vector word with bit 0 cleared |
| viol_o | output | 1 | One-cycle privilege violation pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit status word, the secure bit at 29 and the user bit at 31. With these values the vectors that carry the mode bits in the positions software expects are in range, and so is the overlap where both bits are set. A model in the bench walks the core through every mode transition: secure down to user and back through entry, a guarded return that has to strip the secure bit, each rejected write, and cycles where all three strobes are active together.

// File: rtl/priv_pkg.sv
package priv_pkg;
  typedef enum logic [1:0] {
    MODE_SEC = 2'd0,
    MODE_SUP = 2'd1,
    MODE_USR = 2'd2
  } priv_mode_e;
endpackage

// File: rtl/priv_mode_decode.sv
module priv_mode_decode
  import priv_pkg::*;
(
  input  logic       sec_bit_i,
  input  logic       usr_bit_i,
  output priv_mode_e mode_o
);
  // user bit dominates
  always_comb begin
    if (usr_bit_i)      mode_o = MODE_USR;
    else if (sec_bit_i) mode_o = MODE_SEC;
    else                mode_o = MODE_SUP;
  end
endmodule

// File: rtl/priv_wr_guard.sv
module priv_wr_guard
  import priv_pkg::*;
(
  input  priv_mode_e cur_mode_i,
  input  logic       wr_sec_i,
  input  logic       wr_usr_i,
  output logic       accept_o
);
  always_comb begin
    unique case (cur_mode_i)
      MODE_SEC: accept_o = 1'b1;
      MODE_SUP: accept_o = !wr_sec_i;
      MODE_USR: accept_o = !wr_sec_i && wr_usr_i;
      default:  accept_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/priv_ret_guard.sv
module priv_ret_guard
  import priv_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int SEC_BIT = 29
) (
  input  priv_mode_e      cur_mode_i,
  input  logic [XLEN-1:0] shadow_i,
  output logic [XLEN-1:0] ret_sr_o,
  output logic            strip_o
);
  always_comb begin
    strip_o  = (cur_mode_i != MODE_SEC) && shadow_i[SEC_BIT];
    ret_sr_o = shadow_i;
    if (strip_o) ret_sr_o[SEC_BIT] = 1'b0;
  end
endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
  import priv_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int SEC_BIT = 29,
  parameter int USR_BIT = 31
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exc_valid_i,
  input  logic [XLEN-1:0] exc_vec_i,
  input  logic            sr_we_i,
  input  logic [XLEN-1:0] sr_wdata_i,
  input  logic            eret_i,
  output logic [1:0]      mode_o,
  output logic            secure_o,
  output logic [XLEN-1:0] sr_o,
  output logic [XLEN-1:0] handler_addr_o,
  output logic            viol_o
);
  localparam logic [XLEN-1:0] SR_RST = XLEN'(1) << SEC_BIT;

  logic [XLEN-1:0] sr_q, sr_d, sh_q, sh_d, ret_sr, entry_sr;
  logic            viol_q, viol_d, wr_ok, ret_strip;
  priv_mode_e      cur_mode;

  priv_mode_decode u_dec (
    .sec_bit_i (sr_q[SEC_BIT]),
    .usr_bit_i (sr_q[USR_BIT]),
    .mode_o    (cur_mode)
  );

  priv_wr_guard u_wr (
    .cur_mode_i (cur_mode),
    .wr_sec_i   (sr_wdata_i[SEC_BIT]),
    .wr_usr_i   (sr_wdata_i[USR_BIT]),
    .accept_o   (wr_ok)
  );

  priv_ret_guard #(.XLEN(XLEN), .SEC_BIT(SEC_BIT)) u_ret (
    .cur_mode_i (cur_mode),
    .shadow_i   (sh_q),
    .ret_sr_o   (ret_sr),
    .strip_o    (ret_strip)
  );

  always_comb begin
    entry_sr          = sr_q;
    entry_sr[USR_BIT] = 1'b0;
    entry_sr[SEC_BIT] = exc_vec_i[0];
  end

  // entry > return > write
  always_comb begin
    sr_d   = sr_q;
    sh_d   = sh_q;
    viol_d = 1'b0;
    if (exc_valid_i) begin
      sh_d = sr_q;
      sr_d = entry_sr;
    end else if (eret_i) begin
      sr_d   = ret_sr;
      viol_d = ret_strip;
    end else if (sr_we_i) begin
      if (wr_ok) sr_d = sr_wdata_i;
      else       viol_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= SR_RST;
      sh_q   <= '0;
      viol_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      sh_q   <= sh_d;
      viol_q <= viol_d;
    end
  end

  assign mode_o         = cur_mode;
  assign secure_o       = (cur_mode == MODE_SEC);
  assign sr_o           = sr_q;
  assign handler_addr_o = {exc_vec_i[XLEN-1:1], 1'b0};
  assign viol_o         = viol_q;
endmodule

// File: rtl/priv_mode_chk.sv
module priv_mode_chk #(
  parameter int XLEN    = 32,
  parameter int SEC_BIT = 29,
  parameter int USR_BIT = 31
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            exc_valid_i,
  input logic [XLEN-1:0] exc_vec_i,
  input logic            sr_we_i,
  input logic [XLEN-1:0] sr_wdata_i,
  input logic            eret_i,
  input logic [1:0]      mode_o,
  input logic            secure_o,
  input logic [XLEN-1:0] sr_o,
  input logic            viol_o
);
  // R2
  user_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_o[USR_BIT] |-> mode_o == 2'd2);

  // R2
  secure_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    secure_o == (!sr_o[USR_BIT] && sr_o[SEC_BIT]));

  // R3
  entry_secure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i && exc_vec_i[0] |=> mode_o == 2'd0);

  // R4
  entry_super_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i && !exc_vec_i[0] |=> mode_o == 2'd1);

  // R7
  ret_strip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eret_i && !exc_valid_i && mode_o != 2'd0 |=> !sr_o[SEC_BIT]);

  // R8
  wr_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_i && !exc_valid_i && !eret_i && mode_o != 2'd0 && sr_wdata_i[SEC_BIT]
    |=> viol_o && $stable(sr_o));

  // R12
  viol_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(!exc_valid_i && (sr_we_i || eret_i)));
endmodule

bind priv_mode_ctrl priv_mode_chk #(
  .XLEN(XLEN), .SEC_BIT(SEC_BIT), .USR_BIT(USR_BIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exc_valid_i (exc_valid_i),
  .exc_vec_i   (exc_vec_i),
  .sr_we_i     (sr_we_i),
  .sr_wdata_i  (sr_wdata_i),
  .eret_i      (eret_i),
  .mode_o      (mode_o),
  .secure_o    (secure_o),
  .sr_o        (sr_o),
  .viol_o      (viol_o)
);

// File: tb/sim_priv_mode_ctrl.sv
module sim_priv_mode_ctrl;
  localparam int XLEN = 32;
  localparam logic [31:0] SEC = 32'h2000_0000;
  localparam logic [31:0] USR = 32'h8000_0000;

  typedef struct {
    logic [31:0] sr;
    logic [1:0]  mode;
    logic        viol;
    string       tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        exc_valid_i = 1'b0;
  logic [31:0] exc_vec_i = '0;
  logic        sr_we_i = 1'b0;
  logic [31:0] sr_wdata_i = '0;
  logic        eret_i = 1'b0;
  logic [1:0]  mode_o;
  logic        secure_o;
  logic [31:0] sr_o;
  logic [31:0] handler_addr_o;
  logic        viol_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t q[$];
  logic [31:0] sr_m, sh_m;

  always #2.5 clk_i = ~clk_i;

  priv_mode_ctrl #(.XLEN(XLEN)) u0 (.*);

  function automatic logic [1:0] mode_of(logic [31:0] s);
    if (s[31]) return 2'd2;
    if (s[29]) return 2'd0;
    return 2'd1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit exc, input logic [31:0] vec, input bit we,
                      input logic [31:0] wd, input bit er, input string tag);
    exp_t e;
    bit cur_sec, v;
    logic [31:0] r;
    @(negedge clk_i);
    exc_valid_i = exc; exc_vec_i = vec; sr_we_i = we; sr_wdata_i = wd; eret_i = er;
    cur_sec = sr_m[29] && !sr_m[31];
    v = 1'b0;
    if (exc) begin
      sh_m = sr_m;
      sr_m = (sr_m & ~(SEC | USR)) | (vec[0] ? SEC : 32'h0);
    end else if (er) begin
      r = sh_m;
      if (!cur_sec && r[29]) begin r[29] = 1'b0; v = 1'b1; end
      sr_m = r;
    end else if (we) begin
      if (!cur_sec && (wd[29] || (sr_m[31] && !wd[31]))) v = 1'b1;
      else sr_m = wd;
    end
    e.sr = sr_m; e.mode = mode_of(sr_m); e.viol = v; e.tag = tag;
    q.push_back(e);
    #1;
    // R5
    if (exc) chk(handler_addr_o == {vec[31:1], 1'b0}, "R5 handler address", handler_addr_o, {vec[31:1], 1'b0});
  endtask

  // monitor
  always @(posedge clk_i) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(sr_o == e.sr, {e.tag, " sr"}, sr_o, e.sr);
      chk(mode_o == e.mode, {e.tag, " mode"}, 32'(mode_o), 32'(e.mode));
      chk(secure_o == (e.mode == 2'd0), {e.tag, " R2 secure flag"}, 32'(secure_o), 32'(e.mode == 2'd0));
      chk(viol_o == e.viol, {e.tag, " R12 viol"}, 32'(viol_o), 32'(e.viol));
    end
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    sr_m = SEC; sh_m = '0;
    #12;
    // R1
    chk(sr_o == SEC && mode_o == 2'd0 && secure_o && !viol_o, "R1 reset state", sr_o, SEC);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, "R1 idle");
    step(0, 0, 1, 32'h0000_0055, 0, "R10 secure drops to super");
    step(0, 0, 1, 32'h2000_0055, 0, "R8 super sets secure");
    step(0, 0, 1, 32'h0000_00AA, 0, "R10 super plain write");
    step(1, 32'h0000_1001, 0, 0, 0, "R3 entry to secure");
    step(0, 0, 0, 0, 1, "R6 return from secure");
    step(1, 32'h0000_2000, 0, 0, 0, "R4 entry from super");
    step(0, 0, 1, 32'h8000_00AA, 0, "R10 super to user");
    step(0, 0, 1, 32'h0000_00AA, 0, "R9 user clears user bit");
    step(0, 0, 1, 32'hA000_00AA, 0, "R8 user sets secure");
    step(1, 32'hFFFF_FFFF, 0, 0, 0, "R3 entry from user");
    step(0, 0, 0, 0, 1, "R6 return to user");
    step(1, 32'h0000_0401, 0, 0, 0, "R3 entry to secure again");
    step(0, 0, 1, 32'hA000_0000, 0, "R2 both bits user wins");
    step(1, 32'h0000_0801, 0, 0, 0, "R3 entry from overlap");
    step(0, 0, 1, 32'h2000_0007, 0, "R10 secure write");
    step(1, 32'h0000_0800, 0, 0, 0, "R4 secure caller forced super");
    step(0, 0, 0, 0, 1, "R7 guarded return strips secure");
    step(0, 0, 0, 0, 1, "R6 shadow kept after return");
    step(1, 32'h0000_0011, 1, 32'h0000_0000, 1, "R11 entry wins");
    step(0, 0, 1, 32'h8000_0000, 1, "R11 return beats write");
    step(0, 0, 0, 0, 0, "R12 viol single cycle");
    step(0, 0, 0, 0, 0, "R12 drain");
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule